// File: doc/BRIEF.md
# Oversampled SPI Slave

This block is a serial-peripheral slave that lives entirely in the system clock domain. The serial clock, the active-low select and the master-out data line come in as asynchronous pins. The block never uses them as clocks. Each one passes through a short synchronizer. Serial-clock edges are then found by comparing the newest synchronized sample with the sample one system cycle older. A small state machine uses those edge events to shift bytes in from the master and, at the same time, shift bytes out on the slave-out line.

The clock idles low. A build parameter selects which edge captures data. In the default convention the slave captures on the rising serial edge and changes its output on the falling edge. In the alternative convention it launches on the rising edge and captures on the falling edge, which suits masters that read the idle-low phase the other way round.

Software-side logic writes the next outgoing byte into a holding register with a one-cycle strobe. It collects each received byte, which comes with a one-cycle valid pulse. The design is sized for a system clock of about ten times the serial clock.

Top module: `spi_os_slave`

## Requirements
- R1: The serial clock, select and data inputs each pass through two system-clock flip-flops before any logic uses them, so all three see the same two-cycle latency.
- R2: An edge of the serial clock is detected by comparing the synchronized sample with the sample one system cycle older. Each real serial edge produces exactly one single-cycle event.
- R3: With PHASE = PH_CAPTURE_RISE (value 0), the data line is captured on rising serial edges. With PH_CAPTURE_FALL (value 1), it is captured on falling edges. Bits are assembled most significant bit first into a DATA_W-bit byte (8 by default).
- R4: The slave-out bit changes only in response to a launch edge, which is the serial edge opposite to the capture edge, or on entry into a transfer. It is valid at the master's next capture edge.
- R5: Several bytes may follow one another under one select assertion. Each byte after the first is taken from the holding register at the first launch edge after the previous byte completes. A tx_load pulse writes tx_data into that holding register.
- R6: rx_valid is high for exactly one system cycle after the eighth capture edge of a byte, and rx_data then holds that byte.
- R7: While select is released, the bit counter is held at zero and a partial byte is discarded without a valid pulse. spi_miso_oe is low from the third system edge after the release.
- R8: When select is asserted, the most significant bit of the held byte is on spi_miso, with spi_miso_oe high, before the first capture edge.
- R9: Transfers are correct when the serial high and low times are each as short as three system cycles, including duty cycles other than 50/50.
- R10: During reset, spi_miso_oe, spi_miso, rx_valid and rx_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master, asynchronous, idle low |
| spi_cs_n | input | 1 | Active-low select from the master, asynchronous |
| spi_mosi | input | 1 | Data from the master, asynchronous |
| spi_miso | output | 1 | Data to the master, forced to 0 when not driven |
| spi_miso_oe | output | 1 | Output enable for the slave-out pad (low means high impedance) |
| tx_data | input | DATA_W | Next byte to send |
| tx_load | input | 1 | Writes tx_data into the holding register |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data is new |

## Verification
The bench builds two copies of the slave side by side. One uses PHASE = PH_CAPTURE_RISE and the other PH_CAPTURE_FALL, with default width and synchronizer depth. A behavioural master drives each copy in turn, with shared serial clock and data lines and a separate select for each. Having both conventions in one run allows full-duplex, back-to-back byte exchange and mid-byte select release to be checked for both edge orderings. The run includes high and low times of three system cycles with uneven duty, which puts the launch-to-capture margin at its minimum.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

    // Which serial-clock edge captures incoming data; the other edge launches.
    typedef enum logic {
        PH_CAPTURE_RISE = 1'b0,
        PH_CAPTURE_FALL = 1'b1
    } phase_e;

    // Raw or synchronized view of the three serial inputs.
    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic mosi;
    } pins_t;

    // Events handed from edge detection to the shift engine.
    typedef struct packed {
        logic active;   // select asserted (synchronized)
        logic cap;      // capture edge this cycle
        logic launch;   // launch edge this cycle
        logic mosi;     // data sample aligned with the edge
    } evt_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } state_e;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, mosi: 1'b0};

    function automatic logic capture_on_rise(phase_e ph);
        return ph == PH_CAPTURE_RISE;
    endfunction

endpackage

// File: rtl/spi_os_sync.sv
module spi_os_sync
    import spi_os_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t raw,
    output pins_t now,
    output pins_t prev
);

    pins_t stg [STAGES];
    pins_t older;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= PINS_IDLE;
            older <= PINS_IDLE;
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            older <= stg[STAGES-1];
        end
    end

    assign now  = stg[STAGES-1];
    assign prev = older;

    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_PREV_DELAY: assert property (@(posedge clk) disable iff (rst) (age == 2'd3) |-> prev == $past(now)); // R2

    generate
        if (STAGES == 2) begin : g_two
            AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst) (age == 2'd3) |-> now == $past(raw, 2)); // R1
        end
    endgenerate

endmodule

// File: rtl/spi_os_edge.sv
module spi_os_edge
    import spi_os_pkg::*;
#(
    parameter phase_e PHASE = PH_CAPTURE_RISE
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t now,
    input  pins_t prev,
    output evt_t  evt
);

    logic rise, fall, sel;

    always_comb begin
        rise = now.sclk & ~prev.sclk;
        fall = ~now.sclk & prev.sclk;
        sel  = ~now.cs_n;
        evt.active = sel;
        evt.mosi   = now.mosi;
        if (capture_on_rise(PHASE)) begin
            evt.cap    = sel & rise;
            evt.launch = sel & fall;
        end else begin
            evt.cap    = sel & fall;
            evt.launch = sel & rise;
        end
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst) rise |=> !rise); // R2
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst) fall |=> !fall); // R2

endmodule

// File: rtl/spi_os_core.sv
module spi_os_core
    import spi_os_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_t              evt,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              miso_bit,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    state_e            state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rx_sh, tx_sh, hold;
    logic [DATA_W-1:0] rx_next;

    assign rx_next = {rx_sh[DATA_W-2:0], evt.mosi};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            hold     <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            miso_oe  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            miso_oe  <= evt.active;
            if (tx_load) hold <= tx_data;
            unique case (state)
                ST_IDLE: begin
                    cnt   <= '0;
                    rx_sh <= '0;
                    if (evt.active) begin
                        tx_sh <= hold;
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (!evt.active) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        if (evt.cap) begin
                            rx_sh <= rx_next;
                            if (cnt == LAST) begin
                                cnt      <= '0;
                                rx_data  <= rx_next;
                                rx_valid <= 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        if (evt.launch) begin
                            if (cnt == '0) tx_sh <= hold;
                            else           tx_sh <= tx_sh << 1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign miso_bit = tx_sh[DATA_W-1];

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) rx_valid |=> !rx_valid); // R6
    AST_VALID_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst) rx_valid |-> $past(evt.cap)); // R3
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst) !evt.active |=> (!miso_oe && cnt == '0)); // R7
    AST_MISO_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst) (miso_oe && $stable(miso_oe) && !$stable(tx_sh)) |-> $past(evt.launch)); // R4

endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave
    import spi_os_pkg::*;
#(
    parameter int     DATA_W      = 8,
    parameter int     SYNC_STAGES = 2,
    parameter phase_e PHASE       = PH_CAPTURE_RISE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    pins_t raw, now, prev;
    evt_t  evt;
    logic  miso_bit, oe;

    assign raw = '{sclk: spi_sclk, cs_n: spi_cs_n, mosi: spi_mosi};

    spi_os_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (raw),
        .now (now),
        .prev(prev)
    );

    spi_os_edge #(.PHASE(PHASE)) u_edge (
        .clk (clk),
        .rst (rst),
        .now (now),
        .prev(prev),
        .evt (evt)
    );

    spi_os_core #(.DATA_W(DATA_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .tx_data (tx_data),
        .tx_load (tx_load),
        .miso_bit(miso_bit),
        .miso_oe (oe),
        .rx_data (rx_data),
        .rx_valid(rx_valid)
    );

    assign spi_miso    = oe & miso_bit;
    assign spi_miso_oe = oe;

endmodule

// File: tb/spi_os_slave_test.sv
module spi_os_slave_test;
    import spi_os_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, mosi = 1'b0, csn_a = 1'b1, csn_b = 1'b1;
    logic [W-1:0] txd = '0;
    logic ld_a = 1'b0, ld_b = 1'b0;
    logic miso_a, oe_a, rv_a, miso_b, oe_b, rv_b;
    logic [W-1:0] rxd_a, rxd_b;

    int checks = 0;
    int errors = 0;
    int vcnt = 0;
    logic [W-1:0] exp_a[$], exp_b[$], stx[$];
    logic ha1 = 1'b1, ha2 = 1'b1, ha3 = 1'b1;
    logic hb1 = 1'b1, hb2 = 1'b1, hb3 = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_os_slave #(.DATA_W(W), .PHASE(PH_CAPTURE_RISE)) uut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(csn_a), .spi_mosi(mosi),
        .spi_miso(miso_a), .spi_miso_oe(oe_a), .tx_data(txd), .tx_load(ld_a),
        .rx_data(rxd_a), .rx_valid(rv_a)
    );

    spi_os_slave #(.DATA_W(W), .PHASE(PH_CAPTURE_FALL)) uut_alt (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(csn_b), .spi_mosi(mosi),
        .spi_miso(miso_b), .spi_miso_oe(oe_b), .tx_data(txd), .tx_load(ld_b),
        .rx_data(rxd_b), .rx_valid(rv_b)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] next_val();
        vcnt++;
        return W'((vcnt * 83 + 53) ^ (vcnt << 3));
    endfunction

    // Select history seen at each active edge: enable follows three edges later.
    always @(posedge clk) begin
        ha3 <= ha2; ha2 <= ha1; ha1 <= csn_a;
        hb3 <= hb2; hb2 <= hb1; hb1 <= csn_b;
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (!rst) begin
            chk(oe_a === ~ha3, "R7", 32'(oe_a), 32'(~ha3), "enable follows select (rise cfg)");
            chk(oe_b === ~hb3, "R7", 32'(oe_b), 32'(~hb3), "enable follows select (fall cfg)");
            if (rv_a) begin
                if (exp_a.size() == 0) chk(1'b0, "R7", 32'(rxd_a), 32'hFFFF, "unexpected byte (rise cfg)");
                else begin
                    logic [W-1:0] e;
                    e = exp_a.pop_front();
                    chk(rxd_a === e, "R3", 32'(rxd_a), 32'(e), "received byte (rise cfg)");
                end
            end
            if (rv_b) begin
                if (exp_b.size() == 0) chk(1'b0, "R7", 32'(rxd_b), 32'hFFFF, "unexpected byte (fall cfg)");
                else begin
                    logic [W-1:0] e;
                    e = exp_b.pop_front();
                    chk(rxd_b === e, "R3", 32'(rxd_b), 32'(e), "received byte (fall cfg)");
                end
            end
        end
    end

    // Loader: after each received byte, write the next outgoing byte (R5).
    initial begin
        forever begin
            @(negedge clk);
            ld_a = 1'b0;
            ld_b = 1'b0;
            if ((rv_a || rv_b) && stx.size() > 0) begin
                txd = stx.pop_front();
                ld_a = rv_a;
                ld_b = rv_b;
            end
        end
    end

    task automatic xfer(input bit alt, input int nbytes, input int hi, input int lo, input int cut);
        logic [W-1:0] mb[$], sb[$];
        logic ms;
        for (int i = 0; i < nbytes; i++) begin
            mb.push_back(next_val());
            sb.push_back(next_val());
        end
        if (cut < 0) begin
            foreach (mb[i]) begin
                if (alt) exp_b.push_back(mb[i]);
                else     exp_a.push_back(mb[i]);
            end
        end
        @(negedge clk);
        txd = sb[0];
        if (alt) ld_b = 1'b1; else ld_a = 1'b1;
        @(negedge clk);
        ld_a = 1'b0; ld_b = 1'b0;
        for (int i = 1; i < nbytes; i++) stx.push_back(sb[i]);
        mosi = mb[0][W-1];
        if (alt) csn_b = 1'b0; else csn_a = 1'b0;
        repeat (4) @(negedge clk);
        ms = alt ? miso_b : miso_a;
        chk(ms === sb[0][W-1], "R8", 32'(ms), 32'(sb[0][W-1]), "first bit before capture edge");
        chk((alt ? oe_b : oe_a) === 1'b1, "R8", 32'(alt ? oe_b : oe_a), 32'd1, "driver enabled");
        for (int bi = 0; bi < nbytes * W; bi++) begin
            int k, b;
            if (cut >= 0 && bi == cut) break;
            k = bi / W;
            b = W - 1 - (bi % W);
            if (!alt) begin
                sclk = 1'b1;
                chk(miso_a === sb[k][b], (hi == 3 || lo == 3) ? "R9" : "R4", 32'(miso_a), 32'(sb[k][b]), "miso at capture (rise cfg)");
                repeat (hi) @(negedge clk);
                sclk = 1'b0;
                if (bi + 1 < nbytes * W) mosi = mb[(bi+1)/W][W-1-((bi+1)%W)];
                repeat (lo) @(negedge clk);
            end else begin
                sclk = 1'b1;
                mosi = mb[k][b];
                repeat (hi) @(negedge clk);
                sclk = 1'b0;
                chk(miso_b === sb[k][b], (hi == 3 || lo == 3) ? "R9" : "R4", 32'(miso_b), 32'(sb[k][b]), "miso at capture (fall cfg)");
                repeat (lo) @(negedge clk);
            end
        end
        csn_a = 1'b1; csn_b = 1'b1;
        stx.delete();
        repeat (6) @(negedge clk);
        chk(exp_a.size() == 0 && exp_b.size() == 0, "R5", 32'(exp_a.size() + exp_b.size()), 32'd0, "all bytes delivered");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(oe_a === 1'b0 && oe_b === 1'b0, "R10", 32'({oe_a, oe_b}), 32'd0, "enable in reset");
        chk(rv_a === 1'b0 && rv_b === 1'b0, "R10", 32'({rv_a, rv_b}), 32'd0, "valid in reset");
        chk(rxd_a === '0 && rxd_b === '0, "R10", 32'({rxd_a, rxd_b}), 32'd0, "data in reset");
        chk(miso_a === 1'b0 && miso_b === 1'b0, "R10", 32'({miso_a, miso_b}), 32'd0, "miso in reset");
        rst = 1'b0;
        repeat (5) @(negedge clk);

        xfer(1'b0, 4, 5, 5, -1);   // R5 back-to-back, R3 rise capture
        xfer(1'b0, 3, 3, 7, -1);   // R9 minimum high, uneven duty
        xfer(1'b0, 3, 7, 3, -1);   // R9 minimum low
        xfer(1'b0, 1, 4, 4, 3);    // R7 release mid-byte
        xfer(1'b0, 2, 4, 4, -1);   // R7 counter restarted
        xfer(1'b1, 4, 5, 5, -1);   // R3 fall capture, R5
        xfer(1'b1, 3, 3, 6, -1);   // R9
        xfer(1'b1, 3, 6, 3, -1);   // R9
        xfer(1'b1, 1, 4, 4, 5);    // R7
        xfer(1'b1, 2, 3, 3, -1);   // R9 both minimum
        chk(rv_a === 1'b0 && rv_b === 1'b0, "R6", 32'({rv_a, rv_b}), 32'd0, "valid idle after traffic");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule